// File: doc/BRIEF.md
# APB GPIO Port with Per-Line Interrupt Detection

This block is a general-purpose I/O port behind a zero-wait-state APB slave. It has a parameterized number of lines, 32 by default. Every line has its own direction bit. The output value is written only through a set register and a clear register, so two software tasks can each own different lines and neither has to read the register, change it and write it back. Every input goes through a two-flop synchronizer. After that it can be read back, and it feeds that line's interrupt detector.

Each line's interrupt is configured separately. It can be level sensitive with high or low polarity. It can be edge sensitive on the rising or the falling edge, or on both edges when the either-edge bit is set. Enable and polarity have their own set and clear registers. Edge events latch into a pending bit, and software acknowledges them by writing ones to the status address. A level pending bit follows its condition. All enabled pending bits merge into one registered interrupt output. Reading the status address tells the handler which lines caused it.

Top module: `gpio_apb_irq`

## Requirements
- R1: `gpio_oe[i]` equals bit i of the direction register at byte offset 0x00, which is read/write. A 1 makes the line an output. Each bit is independent of the others.
- R2: Writing offset 0x04 drives high every output bit written as 1. Writing offset 0x08 drives low every output bit written as 1. Bits written as 0 keep their value. `gpio_out` changes at the clock edge of the APB access phase. A read of 0x04 returns the current output value.
- R3: A change on `gpio_in` reaches the input register at offset 0x0C through two flops. A read whose setup phase is one clock edge after the change returns the old value. A read whose setup phase is three edges after the change returns the new value. For an edge line, the pending bit sets at the third edge after the input change, and `irq` rises at the fourth.
- R4: A line whose bit is 0 in the mode register at offset 0x18 is level sensitive. Its pending bit is the synchronized input when its polarity bit is 1, and the inverted synchronized input when its polarity bit is 0.
- R5: A line whose mode bit is 1 is edge sensitive. Polarity 1 selects the rising edge and polarity 0 selects the falling edge. When the line's bit is set in the either-edge register at offset 0x24, both edges count.
- R6: The enable mask reads back at offset 0x10. Writing 0x10 sets the enable bits written as 1, and writing 0x14 clears them. The polarity mask reads back at offset 0x1C. Writing 0x1C sets the polarity bits written as 1, and writing 0x20 clears them. Bits written as 0 are unchanged in all four cases.
- R7: An edge pending bit stays set until a 1 is written to its position at offset 0x28. A write to 0x28 leaves a level pending bit at its condition.
- R8: A read of offset 0x28 returns pending AND enable. `irq` is high one clock after any enabled bit is pending, and it stays low while no line is enabled.
- R9: If an edge is detected in the same cycle as a clear write to that bit, the bit stays pending.
- R10: After reset, direction, output, enable, mode, polarity, either-edge and pending are all 0, and `irq` is low.
- R11: `pready` is always 1 and `pslverr` is always 0. Reads of the write-only offsets 0x08, 0x14 and 0x20 return 0, and so do reads of unmapped offsets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Never an error |
| gpio_in | input | N_LINES | Asynchronous line inputs |
| gpio_out | output | N_LINES | Output values |
| gpio_oe | output | N_LINES | Output enables (1 = drive) |
| irq | output | 1 | Merged interrupt |

## Verification
The hardest case to reach is a clear write that lands in the same cycle as a newly detected edge on the same line. To hit it, the input must change exactly two edges before the APB access phase of the acknowledge write. The bench counts the synchronizer and edge register stages and starts the write setup one cycle after changing the input, so the access edge falls on the detection cycle. The same cycle counting pins down the read-back and interrupt latency of R3. Random rounds then cover mixed mode, polarity, either-edge and enable settings, each with a chosen before-and-after input pattern.

// File: rtl/gpio_apb_pkg.sv
package gpio_apb_pkg;
  // word index of each register (byte offset = index * 4)
  typedef enum logic [3:0] {
    RIX_DIR  = 4'd0,
    RIX_OSET = 4'd1,
    RIX_OCLR = 4'd2,
    RIX_IN   = 4'd3,
    RIX_ESET = 4'd4,
    RIX_ECLR = 4'd5,
    RIX_MODE = 4'd6,
    RIX_PSET = 4'd7,
    RIX_PCLR = 4'd8,
    RIX_ANY  = 4'd9,
    RIX_IRQ  = 4'd10
  } reg_idx_e;

  localparam int RIX_W = 4;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int N_LINES = 32,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] async_in,
  output logic [N_LINES-1:0] sync_out
);
  logic [N_LINES-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_det.sv
module gpio_irq_det #(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] sync_in,
  input  logic [N_LINES-1:0] mode_edge,
  input  logic [N_LINES-1:0] pol_high,
  input  logic [N_LINES-1:0] both_edges,
  input  logic [N_LINES-1:0] enable,
  input  logic [N_LINES-1:0] ack_mask,
  output logic [N_LINES-1:0] pend,
  output logic [N_LINES-1:0] status,
  output logic               irq
);
  logic [N_LINES-1:0] last_q;
  logic [N_LINES-1:0] pend_q;
  logic [N_LINES-1:0] pend_d;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    logic rise, fall, hit, lvl;
    assign rise = sync_in[i] & ~last_q[i];
    assign fall = ~sync_in[i] & last_q[i];
    assign hit  = both_edges[i] ? (rise | fall) : (pol_high[i] ? rise : fall);
    assign lvl  = pol_high[i] ? sync_in[i] : ~sync_in[i];
    // a new edge outranks an acknowledge in the same cycle
    assign pend_d[i] = mode_edge[i] ? (hit | (pend_q[i] & ~ack_mask[i])) : lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= '0;
      pend_q <= '0;
      irq    <= 1'b0;
    end else begin
      last_q <= sync_in;
      pend_q <= pend_d;
      irq    <= |(pend_q & enable);
    end
  end

  assign pend   = pend_q;
  assign status = pend_q & enable;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_apb_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [DATA_W-1:0]  pwdata,
  output logic [DATA_W-1:0]  prdata,
  input  logic [N_LINES-1:0] sync_in,
  input  logic [N_LINES-1:0] status,
  output logic [N_LINES-1:0] dir_q,
  output logic [N_LINES-1:0] out_q,
  output logic [N_LINES-1:0] en_q,
  output logic [N_LINES-1:0] mode_q,
  output logic [N_LINES-1:0] pol_q,
  output logic [N_LINES-1:0] any_q,
  output logic [N_LINES-1:0] ack_mask
);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_LO + RIX_W - 1;

  logic [RIX_W-1:0]   idx;
  logic               in_range;
  logic               wr_en;
  logic               rd_en;
  logic [N_LINES-1:0] wdat;
  logic [N_LINES-1:0] rdval;
  logic [DATA_W-1:0]  rd_word;
  logic               addr_unused;

  assign idx         = paddr[IDX_HI:IDX_LO];
  assign in_range    = (paddr[ADDR_W-1:IDX_HI+1] == '0);
  assign wr_en       = psel & penable & pwrite & in_range;
  assign rd_en       = psel & ~penable & ~pwrite & in_range;
  assign wdat        = pwdata[N_LINES-1:0];
  assign addr_unused = ^paddr[IDX_LO-1:0];

  assign ack_mask = (wr_en && idx == RIX_IRQ) ? wdat : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      out_q  <= '0;
      en_q   <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      any_q  <= '0;
    end else if (wr_en) begin
      case (idx)
        RIX_DIR:  dir_q  <= wdat;
        RIX_OSET: out_q  <= out_q | wdat;
        RIX_OCLR: out_q  <= out_q & ~wdat;
        RIX_ESET: en_q   <= en_q | wdat;
        RIX_ECLR: en_q   <= en_q & ~wdat;
        RIX_MODE: mode_q <= wdat;
        RIX_PSET: pol_q  <= pol_q | wdat;
        RIX_PCLR: pol_q  <= pol_q & ~wdat;
        RIX_ANY:  any_q  <= wdat;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      RIX_DIR:  rdval = dir_q;
      RIX_OSET: rdval = out_q;
      RIX_IN:   rdval = sync_in;
      RIX_ESET: rdval = en_q;
      RIX_MODE: rdval = mode_q;
      RIX_PSET: rdval = pol_q;
      RIX_ANY:  rdval = any_q;
      RIX_IRQ:  rdval = status;
      default:  rdval = '0;
    endcase
    rd_word = '0;
    rd_word[N_LINES-1:0] = rdval;
  end

  // data captured in the setup phase is valid throughout the access phase
  always_ff @(posedge clk) begin
    if (rst)        prdata <= '0;
    else if (rd_en) prdata <= rd_word;
    else            prdata <= '0;
  end
endmodule

// File: rtl/gpio_apb_irq.sv
module gpio_apb_irq #(
  parameter int N_LINES = 32,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [DATA_W-1:0]  pwdata,
  output logic [DATA_W-1:0]  prdata,
  output logic               pready,
  output logic               pslverr,
  input  logic [N_LINES-1:0] gpio_in,
  output logic [N_LINES-1:0] gpio_out,
  output logic [N_LINES-1:0] gpio_oe,
  output logic               irq
);
  logic [N_LINES-1:0] sync_w;
  logic [N_LINES-1:0] status_w;
  logic [N_LINES-1:0] pend_w;
  logic [N_LINES-1:0] en_w;
  logic [N_LINES-1:0] mode_w;
  logic [N_LINES-1:0] pol_w;
  logic [N_LINES-1:0] any_w;
  logic [N_LINES-1:0] ack_w;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  gpio_sync #(.N_LINES(N_LINES), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(gpio_in), .sync_out(sync_w)
  );

  gpio_regs #(.N_LINES(N_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .sync_in(sync_w), .status(status_w),
    .dir_q(gpio_oe), .out_q(gpio_out), .en_q(en_w), .mode_q(mode_w),
    .pol_q(pol_w), .any_q(any_w), .ack_mask(ack_w)
  );

  gpio_irq_det #(.N_LINES(N_LINES)) u_det (
    .clk(clk), .rst(rst), .sync_in(sync_w), .mode_edge(mode_w),
    .pol_high(pol_w), .both_edges(any_w), .enable(en_w), .ack_mask(ack_w),
    .pend(pend_w), .status(status_w), .irq(irq)
  );
endmodule

// File: rtl/gpio_apb_irq_chk.sv
module gpio_apb_irq_chk #(
  parameter int N_LINES = 32,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               psel,
  input logic               penable,
  input logic               pwrite,
  input logic [ADDR_W-1:0]  paddr,
  input logic [DATA_W-1:0]  pwdata,
  input logic [N_LINES-1:0] gpio_out,
  input logic               irq,
  input logic [N_LINES-1:0] pend,
  input logic [N_LINES-1:0] mode,
  input logic [N_LINES-1:0] en
);
  localparam logic [ADDR_W-1:0] A_OSET = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_OCLR = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_IRQ  = ADDR_W'(40);

  logic               wr;
  logic [N_LINES-1:0] wd;
  logic [N_LINES-1:0] ack;

  assign wr  = psel && penable && pwrite;
  assign wd  = pwdata[N_LINES-1:0];
  assign ack = (wr && paddr == A_IRQ) ? wd : '0;

  // R2: bits written to the set register are high afterwards
  a_r2_out_set: assert property (@(posedge clk) disable iff (rst)
    (wr && paddr == A_OSET) |=> ((gpio_out & $past(wd)) == $past(wd)));

  // R2: bits written to the clear register are low afterwards
  a_r2_out_clr: assert property (@(posedge clk) disable iff (rst)
    (wr && paddr == A_OCLR) |=> ((gpio_out & $past(wd)) == '0));

  // R2: outputs hold without a set or clear write
  a_r2_out_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr && (paddr == A_OSET || paddr == A_OCLR)) |=> $stable(gpio_out));

  // R7: an edge pending bit only falls after an acknowledge of that bit
  a_r7_edge_sticky: assert property (@(posedge clk) disable iff (rst)
    ((pend & mode) != '0) |=>
      ((($past(pend & mode) & ~$past(ack)) & mode & ~pend) == '0));

  // R8: no enabled line means no interrupt on the next cycle
  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |=> !irq);
endmodule

bind gpio_apb_irq gpio_apb_irq_chk #(
  .N_LINES(N_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .gpio_out(gpio_out), .irq(irq),
  .pend(pend_w), .mode(mode_w), .en(en_w)
);

// File: tb/sim_gpio_apb_irq.sv
`timescale 1ns/1ps
module sim_gpio_apb_irq;
  localparam int N = 32;
  localparam int AW = 12;
  localparam logic [AW-1:0] O_DIR = 12'h00, O_OSET = 12'h04, O_OCLR = 12'h08,
    O_IN = 12'h0C, O_ESET = 12'h10, O_ECLR = 12'h14, O_MODE = 12'h18,
    O_PSET = 12'h1C, O_PCLR = 12'h20, O_ANY = 12'h24, O_IRQ = 12'h28,
    O_NONE = 12'h30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr;
  logic [N-1:0] gpio_in = '0;
  logic [N-1:0] gpio_out, gpio_oe;
  logic irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gpio_apb_irq u0 (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .gpio_in(gpio_in), .gpio_out(gpio_out),
    .gpio_oe(gpio_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // tasks start and end on a falling edge
  task automatic apb_write(input logic [AW-1:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge clk) penable = 1'b1;
    @(negedge clk) begin psel = 1'b0; penable = 1'b0; pwrite = 1'b0; end
  endtask

  task automatic apb_read(input logic [AW-1:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge clk) penable = 1'b1;
    d = prdata;
    check("R11 pready/pslverr", {30'd0, pready, pslverr}, 32'd2);
    @(negedge clk) begin psel = 1'b0; penable = 1'b0; end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_stat(input logic [31:0] a, input logic [31:0] b,
      input logic [31:0] md, input logic [31:0] pl, input logic [31:0] an,
      input logic [31:0] en);
    logic [31:0] rise, fall, edg, lvl;
    rise = ~a & b;
    fall = a & ~b;
    edg  = (an & (rise | fall)) | (~an & pl & rise) | (~an & ~pl & fall);
    lvl  = (pl & b) | (~pl & ~b);
    return en & ((md & edg) | (~md & lvl));
  endfunction

  initial begin
    #(100000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] a, b, md, pl, an, en, e1;
    void'($urandom(32'h5EED_1234));
    idle(5);
    rst = 1'b0;
    @(negedge clk);

    // R10 reset state
    check("R10 gpio_oe", gpio_oe, 0);
    check("R10 gpio_out", gpio_out, 0);
    check("R10 irq", {31'd0, irq}, 0);
    apb_read(O_DIR, rd);  check("R10 dir", rd, 0);
    apb_read(O_OSET, rd); check("R10 out", rd, 0);
    apb_read(O_ESET, rd); check("R10 enable", rd, 0);
    apb_read(O_MODE, rd); check("R10 mode", rd, 0);
    apb_read(O_PSET, rd); check("R10 polarity", rd, 0);
    apb_read(O_ANY, rd);  check("R10 either", rd, 0);
    apb_read(O_IRQ, rd);  check("R10 status", rd, 0);

    // R1 direction
    apb_write(O_DIR, 32'hA5A5_0F0F);
    check("R1 gpio_oe", gpio_oe, 32'hA5A5_0F0F);
    apb_read(O_DIR, rd); check("R1 dir readback", rd, 32'hA5A5_0F0F);

    // R2 set / clear
    apb_write(O_OSET, 32'h0000_F0F0);
    check("R2 set", gpio_out, 32'h0000_F0F0);
    apb_write(O_OCLR, 32'h0000_3030);
    check("R2 clear", gpio_out, 32'h0000_C0C0);
    apb_write(O_OSET, 32'h0);
    check("R2 zero set", gpio_out, 32'h0000_C0C0);
    apb_write(O_OCLR, 32'h0);
    apb_read(O_OSET, rd); check("R2 zero clear readback", rd, 32'h0000_C0C0);

    // R11 write-only and unmapped reads
    apb_read(O_OCLR, rd); check("R11 out-clear read", rd, 0);
    apb_read(O_ECLR, rd); check("R11 enable-clear read", rd, 0);
    apb_read(O_PCLR, rd); check("R11 polarity-clear read", rd, 0);
    apb_read(O_NONE, rd); check("R11 unmapped read", rd, 0);

    // R6 enable and polarity set/clear
    apb_write(O_ESET, 32'h0000_000F);
    apb_write(O_ECLR, 32'h0000_0005);
    apb_read(O_ESET, rd); check("R6 enable", rd, 32'h0000_000A);
    apb_write(O_PSET, 32'hF000_0000);
    apb_write(O_PCLR, 32'h5000_0000);
    apb_read(O_PSET, rd); check("R6 polarity", rd, 32'hA000_0000);
    apb_write(O_ECLR, 32'hFFFF_FFFF);
    apb_write(O_PCLR, 32'hFFFF_FFFF);

    // R3 read-back latency
    gpio_in = 32'h0000_00FF;
    idle(4);
    gpio_in = 32'h1234_5678;
    apb_read(O_IN, rd); check("R3 old value after one edge", rd, 32'h0000_00FF);
    apb_read(O_IN, rd); check("R3 new value after three edges", rd, 32'h1234_5678);

    // R3 / R5 interrupt latency on a rising edge line
    gpio_in = '0;
    apb_write(O_MODE, 32'h3);
    apb_write(O_PSET, 32'h3);
    idle(4);
    apb_write(O_IRQ, 32'hFFFF_FFFF);
    apb_write(O_ESET, 32'h1);
    idle(2);
    gpio_in[0] = 1'b1;
    idle(3);
    check("R3 irq low at third edge", {31'd0, irq}, 0);
    idle(1);
    check("R3 irq high at fourth edge", {31'd0, irq}, 1);
    apb_write(O_IRQ, 32'h1);
    idle(1);
    check("R7 acknowledge drops irq", {31'd0, irq}, 0);

    // R9 edge coinciding with acknowledge
    apb_write(O_ESET, 32'h2);
    gpio_in[1] = 1'b1;
    @(negedge clk);
    apb_write(O_IRQ, 32'h2);
    idle(1);
    apb_read(O_IRQ, rd); check("R9 edge kept over clear", rd, 32'h2);
    check("R9 irq", {31'd0, irq}, 1);
    apb_write(O_IRQ, 32'h2);
    idle(1);
    apb_read(O_IRQ, rd); check("R7 later clear", rd, 0);

    // random rounds: R4 R5 R7 R8
    for (int r = 0; r < 40; r++) begin
      a = $urandom(); b = (r % 4 == 0) ? ~a : $urandom();
      md = $urandom(); pl = $urandom(); an = $urandom(); en = $urandom();
      if (r == 1) en = '0;
      gpio_in = a;
      apb_write(O_MODE, md);
      apb_write(O_ANY, an);
      apb_write(O_ESET, 32'hFFFF_FFFF);
      apb_write(O_ECLR, ~en);
      apb_write(O_PSET, 32'hFFFF_FFFF);
      apb_write(O_PCLR, ~pl);
      idle(4);
      apb_write(O_IRQ, 32'hFFFF_FFFF);
      idle(4);
      gpio_in = b;
      idle(6);
      e1 = exp_stat(a, b, md, pl, an, en);
      apb_read(O_IRQ, rd); check("R4/R5 status after change", rd, e1);
      check("R8 merged irq", {31'd0, irq}, {31'd0, |e1});
      apb_write(O_IRQ, 32'hFFFF_FFFF);
      idle(3);
      apb_read(O_IRQ, rd); check("R7 clear keeps level only", rd, en & ~md & ((pl & b) | (~pl & ~b)));
      check("R8 irq after clear", {31'd0, irq}, {31'd0, |(en & ~md & ((pl & b) | (~pl & ~b)))});
    end

    finish_run();
  end
endmodule